// File: doc/BRIEF.md
# Configuration signal routing matrix

This block sits between one target FPGA's configuration pins and every source that can configure it: an on-board serial PROM, an upstream configuration connector and a cable header. A three-bit selector picks one of eight routing setups. These cover the target as a bus master (serial or byte-wide, fed from the PROM or from upstream), as a slave (serial or byte-wide), a JTAG setup, and an external setup in which the block lets go of every pin. In the master setups, the configuration clock and data that the target consumes are also passed to a downstream connector, so that further boards can be chained behind it.

The block drives the target's mode pins, chip select and read/write wherever it owns them, and passes them through where the upstream side owns them. It steers the configuration clock and either the single serial lane or the whole byte lane. In the byte-wide slave setup it also turns the data bus round for readback. Toward upstream it combines the target's INIT and DONE with those of the downstream board. A missing downstream board counts as high on both.

Each driven pin group comes out as a value plus an output enable; a pad ring turns that pair into a tri-state pin. The selector input is asynchronous. It passes through two synchronizer flops and must then hold still for `SETTLE_CYCLES` clocks before a setup takes effect. Until then every enable is low.

Top module: `cfg_route_matrix`

## Requirements
- R1: After reset, and from the second clock after any change of the synchronized selector, every enable (target clock, target data, target mode pins, target control, downstream, source readback) is low. A selector value takes effect on the clock edge SETTLE_CYCLES+3 after it is applied, counted from the first edge, and only if it has not changed in between. Until the second edge the previous setup still holds.
- R2: Selector 0 (master serial, PROM) and 1 (master serial, upstream): the mode pins are driven to 000 and the target clock is not driven. Only data lane 0 is driven, from the PROM serial bit (0) or from lane 0 of the selected upstream source (1). The target's clock and that data bit go to the downstream clock and downstream lane 0 with the downstream enable high. The target's clock is returned on the PROM clock output (0) or on the source clock output (1).
- R3: Selector 2 (master byte, PROM): mode pins 011, chip select driven 0 and read/write driven 1, all data lanes from the PROM byte, target clock to the PROM clock output. Selector 3 (master byte, upstream): mode pins, chip select and read/write taken from the selected source, data from the source byte, target clock to the source clock output. In both setups the target clock and the byte go downstream.
- R4: Selector 4 (slave serial): the target clock, data lane 0, mode pins, chip select and read/write all come from the selected source. The downstream enable stays low.
- R5: Selector 5 (JTAG): mode pins driven to 101. Clock, data, chip select and read/write are released and nothing goes downstream.
- R6: Selector 6 (byte slave): mode pins 110, with clock, chip select and read/write from the selected source. When the selected read/write is 1 the source byte drives all target lanes. When it is 0 the target lanes are released, and the target's byte is returned to the source with the readback enable high.
- R7: Selector 7 (external): every enable is low, whatever the sources do.
- R8: The upstream INIT equals target INIT AND (downstream INIT OR NOT downstream present), and the upstream DONE is formed the same way from the DONE signals. This holds in every setup and also while unsettled.
- R9: A header-select input of 1 takes clock, data, mode, chip select and read/write from the cable header; 0 takes them from the upstream connector. This applies in every upstream-sourced setup (1, 3, 4, 6).
- R10: Every output value that is not enabled reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Raw routing selector (asynchronous) |
| hdr_sel | input | 1 | 1: cable header is the upstream source, 0: connector |
| prom_din | input | 1 | PROM serial data |
| prom_byte | input | DATA_W | PROM byte-wide data |
| prom_cclk_o | output | 1 | Configuration clock returned to the PROM |
| conn_cclk | input | 1 | Upstream connector clock |
| conn_data | input | DATA_W | Upstream connector data |
| conn_mode | input | 3 | Upstream connector mode pins |
| conn_cs | input | 1 | Upstream connector chip select |
| conn_rdwr | input | 1 | Upstream connector read/write |
| hdr_cclk | input | 1 | Cable header clock |
| hdr_data | input | DATA_W | Cable header data |
| hdr_mode | input | 3 | Cable header mode pins |
| hdr_cs | input | 1 | Cable header chip select |
| hdr_rdwr | input | 1 | Cable header read/write |
| src_cclk_o | output | 1 | Target clock returned to the upstream source |
| src_data_o | output | DATA_W | Readback byte toward the source |
| src_data_oe | output | 1 | Readback enable |
| src_init_o | output | 1 | Combined chain INIT toward upstream |
| src_done_o | output | 1 | Combined chain DONE toward upstream |
| tgt_cclk_i | input | 1 | Clock driven by the target as master |
| tgt_data_i | input | DATA_W | Byte driven by the target in readback |
| tgt_init_i | input | 1 | Target INIT |
| tgt_done_i | input | 1 | Target DONE |
| tgt_cclk_o | output | 1 | Clock to the target |
| tgt_cclk_oe | output | 1 | Target clock enable |
| tgt_data_o | output | DATA_W | Data to the target |
| tgt_data_oe | output | DATA_W | Per-lane data enable |
| tgt_mode_o | output | 3 | Target mode pins |
| tgt_mode_oe | output | 1 | Mode pin enable |
| tgt_cs_o | output | 1 | Target chip select |
| tgt_rdwr_o | output | 1 | Target read/write |
| tgt_ctl_oe | output | 1 | Chip select and read/write enable |
| dn_present | input | 1 | Downstream board fitted |
| dn_init_i | input | 1 | Downstream INIT |
| dn_done_i | input | 1 | Downstream DONE |
| dn_cclk_o | output | 1 | Forwarded clock |
| dn_data_o | output | DATA_W | Forwarded data |
| dn_oe | output | 1 | Downstream enable |

## Verification
The assertions assume the source inputs are ordinary two-valued levels while reset is inactive. They also assume the selector may change at any clock, because the filter, not the stimulus, is what guarantees a bus never fights a readback. The bench changes the selector only on falling edges and lets each setup settle before it sweeps data, clock, read/write and header-select levels. It then deliberately changes the selector early and glitches it, to reach the released window that the assertions guard.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    RM_MSER_PROM = 3'd0,
    RM_MSER_UP   = 3'd1,
    RM_MBYTE_PROM = 3'd2,
    RM_MBYTE_UP  = 3'd3,
    RM_SSER      = 3'd4,
    RM_JTAG      = 3'd5,
    RM_SBYTE     = 3'd6,
    RM_EXT       = 3'd7
  } route_mode_e;

  localparam logic [MODE_W-1:0] PINS_MSER  = 3'b000;
  localparam logic [MODE_W-1:0] PINS_MBYTE = 3'b011;
  localparam logic [MODE_W-1:0] PINS_JTAG  = 3'b101;
  localparam logic [MODE_W-1:0] PINS_SBYTE = 3'b110;
endpackage

// File: rtl/cfg_mode_settle.sv
module cfg_mode_settle
  import cfg_route_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] sel_raw,
  output route_mode_e       mode_q,
  output logic              mode_valid
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_CYCLES);

  logic [MODE_W-1:0] sync1_q, sync2_q, cand_q, cand_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cand_d = cand_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (sync2_q != cand_q) begin
      cand_d = sync2_q;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (cnt_q != CNT_MAX) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= RM_EXT;
      sync2_q <= RM_EXT;
      cand_q  <= RM_EXT;
      cnt_q   <= '0;
    end else begin
      sync1_q <= sel_raw;
      sync2_q <= sync1_q;
      if (cnt_en) begin
        cand_q <= cand_d;
        cnt_q  <= cnt_d;
      end
    end
  end

  assign mode_q     = route_mode_e'(cand_q);
  assign mode_valid = (cnt_q == CNT_MAX) && (sync2_q == cand_q);

  // R1: a settled setup never switches without passing through a released cycle
  assert_hold_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_valid && $past(mode_valid)) |-> $stable(mode_q));
endmodule

// File: rtl/cfg_chain_status.sv
module cfg_chain_status #(
  parameter int N_LINES = 2
) (
  input  logic [N_LINES-1:0] local_i,
  input  logic [N_LINES-1:0] dn_i,
  input  logic               dn_present,
  output logic [N_LINES-1:0] up_o
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    // absent board reads as a pulled-up line
    assign up_o[g] = local_i[g] & (dn_i[g] | ~dn_present);
  end
endmodule

// File: rtl/cfg_route_xbar.sv
module cfg_route_xbar
  import cfg_route_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  route_mode_e       mode,
  input  logic              mode_valid,
  input  logic              hdr_sel,
  input  logic              prom_din,
  input  logic [DATA_W-1:0] prom_byte,
  input  logic              conn_cclk,
  input  logic [DATA_W-1:0] conn_data,
  input  logic [MODE_W-1:0] conn_mode,
  input  logic              conn_cs,
  input  logic              conn_rdwr,
  input  logic              hdr_cclk,
  input  logic [DATA_W-1:0] hdr_data,
  input  logic [MODE_W-1:0] hdr_mode,
  input  logic              hdr_cs,
  input  logic              hdr_rdwr,
  input  logic              tgt_cclk_i,
  input  logic [DATA_W-1:0] tgt_data_i,
  output logic              prom_cclk_o,
  output logic              src_cclk_o,
  output logic [DATA_W-1:0] src_data_o,
  output logic              src_data_oe,
  output logic              tgt_cclk_o,
  output logic              tgt_cclk_oe,
  output logic [DATA_W-1:0] tgt_data_o,
  output logic [DATA_W-1:0] tgt_data_oe,
  output logic [MODE_W-1:0] tgt_mode_o,
  output logic              tgt_mode_oe,
  output logic              tgt_cs_o,
  output logic              tgt_rdwr_o,
  output logic              tgt_ctl_oe,
  output logic              dn_cclk_o,
  output logic [DATA_W-1:0] dn_data_o,
  output logic              dn_oe
);
  localparam logic [DATA_W-1:0] LANE0 = DATA_W'(1);
  localparam logic [DATA_W-1:0] LANES = '1;

  logic              s_cclk, s_cs, s_rdwr;
  logic [DATA_W-1:0] s_data;
  logic [MODE_W-1:0] s_mode;

  always_comb begin
    s_cclk = hdr_sel ? hdr_cclk : conn_cclk;
    s_data = hdr_sel ? hdr_data : conn_data;
    s_mode = hdr_sel ? hdr_mode : conn_mode;
    s_cs   = hdr_sel ? hdr_cs   : conn_cs;
    s_rdwr = hdr_sel ? hdr_rdwr : conn_rdwr;

    prom_cclk_o = 1'b0;  src_cclk_o  = 1'b0;
    src_data_o  = '0;    src_data_oe = 1'b0;
    tgt_cclk_o  = 1'b0;  tgt_cclk_oe = 1'b0;
    tgt_data_o  = '0;    tgt_data_oe = '0;
    tgt_mode_o  = '0;    tgt_mode_oe = 1'b0;
    tgt_cs_o    = 1'b0;  tgt_rdwr_o  = 1'b0;  tgt_ctl_oe = 1'b0;
    dn_cclk_o   = 1'b0;  dn_data_o   = '0;    dn_oe      = 1'b0;

    if (mode_valid) begin
      case (mode)
        RM_MSER_PROM, RM_MSER_UP: begin
          tgt_mode_o  = PINS_MSER;
          tgt_mode_oe = 1'b1;
          tgt_data_o  = (mode == RM_MSER_PROM) ? DATA_W'(prom_din) : DATA_W'(s_data[0]);
          tgt_data_oe = LANE0;
          dn_cclk_o   = tgt_cclk_i;
          dn_data_o   = tgt_data_o;
          dn_oe       = 1'b1;
          if (mode == RM_MSER_PROM) prom_cclk_o = tgt_cclk_i;
          else                      src_cclk_o  = tgt_cclk_i;
        end
        RM_MBYTE_PROM: begin
          tgt_mode_o  = PINS_MBYTE;
          tgt_mode_oe = 1'b1;
          tgt_cs_o    = 1'b0;
          tgt_rdwr_o  = 1'b1;
          tgt_ctl_oe  = 1'b1;
          tgt_data_o  = prom_byte;
          tgt_data_oe = LANES;
          dn_cclk_o   = tgt_cclk_i;
          dn_data_o   = prom_byte;
          dn_oe       = 1'b1;
          prom_cclk_o = tgt_cclk_i;
        end
        RM_MBYTE_UP: begin
          tgt_mode_o  = s_mode;
          tgt_mode_oe = 1'b1;
          tgt_cs_o    = s_cs;
          tgt_rdwr_o  = s_rdwr;
          tgt_ctl_oe  = 1'b1;
          tgt_data_o  = s_data;
          tgt_data_oe = LANES;
          dn_cclk_o   = tgt_cclk_i;
          dn_data_o   = s_data;
          dn_oe       = 1'b1;
          src_cclk_o  = tgt_cclk_i;
        end
        RM_SSER: begin
          tgt_cclk_o  = s_cclk;
          tgt_cclk_oe = 1'b1;
          tgt_data_o  = DATA_W'(s_data[0]);
          tgt_data_oe = LANE0;
          tgt_mode_o  = s_mode;
          tgt_mode_oe = 1'b1;
          tgt_cs_o    = s_cs;
          tgt_rdwr_o  = s_rdwr;
          tgt_ctl_oe  = 1'b1;
        end
        RM_JTAG: begin
          tgt_mode_o  = PINS_JTAG;
          tgt_mode_oe = 1'b1;
        end
        RM_SBYTE: begin
          tgt_mode_o  = PINS_SBYTE;
          tgt_mode_oe = 1'b1;
          tgt_cclk_o  = s_cclk;
          tgt_cclk_oe = 1'b1;
          tgt_cs_o    = s_cs;
          tgt_rdwr_o  = s_rdwr;
          tgt_ctl_oe  = 1'b1;
          if (s_rdwr) begin
            tgt_data_o  = s_data;
            tgt_data_oe = LANES;
          end else begin
            src_data_o  = tgt_data_i;
            src_data_oe = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_route_matrix.sv
module cfg_route_matrix
  import cfg_route_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int SETTLE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_sel,
  input  logic              hdr_sel,
  input  logic              prom_din,
  input  logic [DATA_W-1:0] prom_byte,
  output logic              prom_cclk_o,
  input  logic              conn_cclk,
  input  logic [DATA_W-1:0] conn_data,
  input  logic [2:0]        conn_mode,
  input  logic              conn_cs,
  input  logic              conn_rdwr,
  input  logic              hdr_cclk,
  input  logic [DATA_W-1:0] hdr_data,
  input  logic [2:0]        hdr_mode,
  input  logic              hdr_cs,
  input  logic              hdr_rdwr,
  output logic              src_cclk_o,
  output logic [DATA_W-1:0] src_data_o,
  output logic              src_data_oe,
  output logic              src_init_o,
  output logic              src_done_o,
  input  logic              tgt_cclk_i,
  input  logic [DATA_W-1:0] tgt_data_i,
  input  logic              tgt_init_i,
  input  logic              tgt_done_i,
  output logic              tgt_cclk_o,
  output logic              tgt_cclk_oe,
  output logic [DATA_W-1:0] tgt_data_o,
  output logic [DATA_W-1:0] tgt_data_oe,
  output logic [2:0]        tgt_mode_o,
  output logic              tgt_mode_oe,
  output logic              tgt_cs_o,
  output logic              tgt_rdwr_o,
  output logic              tgt_ctl_oe,
  input  logic              dn_present,
  input  logic              dn_init_i,
  input  logic              dn_done_i,
  output logic              dn_cclk_o,
  output logic [DATA_W-1:0] dn_data_o,
  output logic              dn_oe
);
  localparam int N_STATUS = 2;

  logic              rst_meta_q, rst_sync_n;
  route_mode_e       mode;
  logic              mode_valid;
  logic [N_STATUS-1:0] status_up;
  logic              any_oe;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  cfg_mode_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_sync_n), .sel_raw(mode_sel),
    .mode_q(mode), .mode_valid(mode_valid)
  );

  cfg_route_xbar #(.DATA_W(DATA_W)) u_xbar (
    .mode(mode), .mode_valid(mode_valid), .hdr_sel(hdr_sel),
    .prom_din(prom_din), .prom_byte(prom_byte),
    .conn_cclk(conn_cclk), .conn_data(conn_data), .conn_mode(conn_mode),
    .conn_cs(conn_cs), .conn_rdwr(conn_rdwr),
    .hdr_cclk(hdr_cclk), .hdr_data(hdr_data), .hdr_mode(hdr_mode),
    .hdr_cs(hdr_cs), .hdr_rdwr(hdr_rdwr),
    .tgt_cclk_i(tgt_cclk_i), .tgt_data_i(tgt_data_i),
    .prom_cclk_o(prom_cclk_o), .src_cclk_o(src_cclk_o),
    .src_data_o(src_data_o), .src_data_oe(src_data_oe),
    .tgt_cclk_o(tgt_cclk_o), .tgt_cclk_oe(tgt_cclk_oe),
    .tgt_data_o(tgt_data_o), .tgt_data_oe(tgt_data_oe),
    .tgt_mode_o(tgt_mode_o), .tgt_mode_oe(tgt_mode_oe),
    .tgt_cs_o(tgt_cs_o), .tgt_rdwr_o(tgt_rdwr_o), .tgt_ctl_oe(tgt_ctl_oe),
    .dn_cclk_o(dn_cclk_o), .dn_data_o(dn_data_o), .dn_oe(dn_oe)
  );

  cfg_chain_status #(.N_LINES(N_STATUS)) u_status (
    .local_i({tgt_done_i, tgt_init_i}), .dn_i({dn_done_i, dn_init_i}),
    .dn_present(dn_present), .up_o(status_up)
  );

  assign src_init_o = status_up[0];
  assign src_done_o = status_up[1];

  assign any_oe = tgt_cclk_oe | (|tgt_data_oe) | tgt_mode_oe | tgt_ctl_oe
                | dn_oe | src_data_oe;

  assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mode_valid |-> !any_oe);

  assert_ext_release_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_valid && mode == RM_EXT) |-> !any_oe);

  assert_no_fight_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !((|tgt_data_oe) && src_data_oe));

  assert_cclk_owner_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tgt_cclk_oe |-> (mode == RM_SSER || mode == RM_SBYTE));

  assert_init_merge_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    src_init_o |-> (tgt_init_i && (dn_init_i || !dn_present)));

  assert_done_merge_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    src_done_o |-> (tgt_done_i && (dn_done_i || !dn_present)));
endmodule

// File: tb/tb_cfg_route_matrix.sv
module tb_cfg_route_matrix;
  localparam int W  = 8;
  localparam int ST = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] mode_sel;
  logic hdr_sel, prom_din, conn_cclk, conn_cs, conn_rdwr, hdr_cclk, hdr_cs, hdr_rdwr;
  logic [W-1:0] prom_byte, conn_data, hdr_data, tgt_data_i;
  logic [2:0] conn_mode, hdr_mode;
  logic tgt_cclk_i, tgt_init_i, tgt_done_i, dn_present, dn_init_i, dn_done_i;
  logic prom_cclk_o, src_cclk_o, src_data_oe, src_init_o, src_done_o;
  logic [W-1:0] src_data_o, tgt_data_o, tgt_data_oe, dn_data_o;
  logic tgt_cclk_o, tgt_cclk_oe, tgt_mode_oe, tgt_cs_o, tgt_rdwr_o, tgt_ctl_oe;
  logic dn_cclk_o, dn_oe;
  logic [2:0] tgt_mode_o;

  int checks = 0, failures = 0, cyc = 0;

  always #4 clk = ~clk;

  cfg_route_matrix #(.DATA_W(W), .SETTLE_CYCLES(ST)) dut (.*);

  wire [45:0] obs = {tgt_cclk_o, tgt_cclk_oe, tgt_data_o, tgt_data_oe, tgt_mode_o,
                     tgt_mode_oe, tgt_cs_o, tgt_rdwr_o, tgt_ctl_oe, dn_cclk_o,
                     dn_data_o, dn_oe, src_cclk_o, src_data_o, src_data_oe, prom_cclk_o};
  wire any_oe = tgt_cclk_oe | (|tgt_data_oe) | tgt_mode_oe | tgt_ctl_oe | dn_oe | src_data_oe;

  function automatic logic [45:0] model(int m);
    logic cc, coe, mo_e, cs, rw, ctl, dc, doe, sc, roe, pc;
    logic [W-1:0] d, de, dd, rd;
    logic [2:0] mo;
    logic s_cclk, s_cs, s_rw;
    logic [W-1:0] s_d;
    logic [2:0] s_m;
    s_cclk = hdr_sel ? hdr_cclk : conn_cclk;
    s_d = hdr_sel ? hdr_data : conn_data;
    s_m = hdr_sel ? hdr_mode : conn_mode;
    s_cs = hdr_sel ? hdr_cs : conn_cs;
    s_rw = hdr_sel ? hdr_rdwr : conn_rdwr;
    {cc, coe, mo_e, cs, rw, ctl, dc, doe, sc, roe, pc} = '0;
    d = '0; de = '0; dd = '0; rd = '0; mo = '0;
    case (m)
      0, 1: begin
        mo = 3'b000; mo_e = 1; d[0] = (m == 0) ? prom_din : s_d[0]; de = 8'h01;
        dc = tgt_cclk_i; dd[0] = d[0]; doe = 1;
        if (m == 0) pc = tgt_cclk_i; else sc = tgt_cclk_i;
      end
      2: begin
        mo = 3'b011; mo_e = 1; cs = 0; rw = 1; ctl = 1; d = prom_byte; de = 8'hFF;
        dc = tgt_cclk_i; dd = prom_byte; doe = 1; pc = tgt_cclk_i;
      end
      3: begin
        mo = s_m; mo_e = 1; cs = s_cs; rw = s_rw; ctl = 1; d = s_d; de = 8'hFF;
        dc = tgt_cclk_i; dd = s_d; doe = 1; sc = tgt_cclk_i;
      end
      4: begin
        cc = s_cclk; coe = 1; d[0] = s_d[0]; de = 8'h01; mo = s_m; mo_e = 1;
        cs = s_cs; rw = s_rw; ctl = 1;
      end
      5: begin mo = 3'b101; mo_e = 1; end
      6: begin
        mo = 3'b110; mo_e = 1; cc = s_cclk; coe = 1; cs = s_cs; rw = s_rw; ctl = 1;
        if (s_rw) begin d = s_d; de = 8'hFF; end
        else begin rd = tgt_data_i; roe = 1; end
      end
      default: ;
    endcase
    return {cc, coe, d, de, mo, mo_e, cs, rw, ctl, dc, dd, doe, sc, rd, roe, pc};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic set_mode(logic [2:0] m);
    @(negedge clk);
    mode_sel = m;
    repeat (ST + 6) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic string tag_of(int m);
    case (m)
      0, 1: return "R2";
      2, 3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [3];
    pats[0] = 8'hA5; pats[1] = 8'h5A; pats[2] = 8'hC3;
    rst_n = 0; mode_sel = 3'd2; hdr_sel = 0;
    prom_din = 1; prom_byte = 8'h96; conn_cclk = 1; conn_data = 8'hFF; conn_mode = 3'b111;
    conn_cs = 1; conn_rdwr = 1; hdr_cclk = 1; hdr_data = 8'hFF; hdr_mode = 3'b111;
    hdr_cs = 1; hdr_rdwr = 1; tgt_cclk_i = 1; tgt_data_i = 8'hFF;
    tgt_init_i = 1; tgt_done_i = 1; dn_present = 1; dn_init_i = 1; dn_done_i = 1;
    repeat (5) @(negedge clk);
    check("R1 reset enables", {63'b0, any_oe}, 64'd0);
    check("R10 reset values", {18'b0, obs}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release unsettled", {63'b0, any_oe}, 64'd0);

    // full sweep of setups, header select, read/write and data patterns
    for (int m = 0; m < 8; m++) begin
      set_mode(3'(m));
      for (int hs = 0; hs < 2; hs++) begin
        for (int rw = 0; rw < 2; rw++) begin
          for (int p = 0; p < 3; p++) begin
            logic [7:0] v;
            v = pats[p];
            hdr_sel = hs[0];
            conn_data = v; hdr_data = ~v; prom_byte = v ^ 8'h3C; prom_din = v[1];
            conn_cclk = v[0]; hdr_cclk = ~v[0]; tgt_cclk_i = v[2];
            conn_mode = v[2:0]; hdr_mode = v[7:5]; conn_cs = v[3]; hdr_cs = ~v[3];
            conn_rdwr = rw[0]; hdr_rdwr = ~rw[0]; tgt_data_i = v ^ 8'hF0;
            @(negedge clk);
            check({tag_of(m), (hs == 1) ? " R9" : "", " R10"}, {18'b0, obs}, {18'b0, model(m)});
          end
        end
      end
    end

    // R1: selector change timing from settled byte-master PROM to byte slave
    set_mode(3'd2);
    mode_sel = 3'd6;
    @(posedge clk); @(negedge clk);
    check("R1 old setup held one edge", {61'b0, tgt_mode_o}, 64'd3);
    @(posedge clk); @(negedge clk);
    check("R1 released after sync", {63'b0, any_oe}, 64'd0);
    repeat (ST) @(posedge clk);
    @(negedge clk);
    check("R1 still released before settle", {63'b0, any_oe}, 64'd0);
    @(posedge clk); @(negedge clk);
    check("R1 takes effect after settle", {60'b0, tgt_mode_oe, tgt_mode_o}, 64'hE);

    // R1: short glitch restarts the settle window
    mode_sel = 3'd5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    mode_sel = 3'd6;
    repeat (ST / 2) @(posedge clk);
    @(negedge clk);
    check("R1 glitch released", {63'b0, any_oe}, 64'd0);
    repeat (ST + 6) @(posedge clk);
    @(negedge clk);
    check("R1 glitch resettled", {60'b0, tgt_mode_oe, tgt_mode_o}, 64'hE);

    // R8: status merge sweep
    for (int k = 0; k < 32; k++) begin
      logic ei, ed;
      {tgt_init_i, dn_init_i, tgt_done_i, dn_done_i, dn_present} = 5'(k);
      @(negedge clk);
      ei = tgt_init_i & (dn_init_i | ~dn_present);
      ed = tgt_done_i & (dn_done_i | ~dn_present);
      check("R8 status merge", {62'b0, src_done_o, src_init_o}, {62'b0, ed, ei});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule